// File: doc/BRIEF.md
# Burst Byte-Enable Legality Checker

This block watches a request stream on a 32-bit memory-mapped bus and judges every data phase by its four byte-enable bits. Whether a pattern is allowed depends on where the beat sits: a lone access may touch any single byte, either aligned half, or the whole word. A beat inside a multi-beat burst must keep the data contiguous with its neighbours. The opening beat may only leave low bytes out, the closing beat may only leave high bytes out, and the beats in between must be full.

The stream supplies a valid strobe, the byte enables, a start marker and, on the start beat, the burst length in beats. An internal down-counter tracks how many beats of the open burst remain, and from it the block tells the first, middle and last positions apart. The block raises a combinational legal flag for each valid beat. It also keeps a sticky error flag that holds the in-burst index of the first offending beat until software-visible logic pulses a synchronous clear.

Top module: `be_burst_check`

## Requirements
- R1: A start beat with length 1 is a single access; the legal patterns are 4'b1111, 4'b0011, 4'b1100, 4'b0001, 4'b0010, 4'b0100 and 4'b1000, and every other pattern is illegal.
- R2: A start beat with length 2 or more is a burst's first beat; only 4'b1111, 4'b1100 and 4'b1000 are legal.
- R3: A non-start beat with two or more beats still remaining, counting itself, is a middle beat; only 4'b1111 is legal.
- R4: A non-start beat with exactly one beat remaining is the burst's last beat; only 4'b1111, 4'b0011 and 4'b0001 are legal.
- R5: Byte enables of 4'b0000 are illegal in every position.
- R6: A start beat loads the remaining count with its length. Each valid beat then decrements the count. A start beat restarts counting even when the previous burst is unfinished.
- R7: A valid non-start beat arriving with no beats remaining is illegal. A start beat with length 0 is illegal and leaves no burst open.
- R8: `beat_ok` is high in the same cycle exactly when `in_valid` is high and the beat is legal; it is low whenever `in_valid` is low.
- R9: The first illegal valid beat sets `err_flag` one clock later. `err_beat` takes that beat's index, which is 0 on a start beat and counts up by one for each later valid beat, modulo 2^LEN_W. Both then hold until cleared, and later illegal beats do not alter them.
- R10: `clr` high at a clock edge clears `err_flag` and `err_beat` to zero. It takes priority over an illegal beat in the same cycle, and that beat is not recorded.
- R11: After reset, `err_flag` and `err_beat` are zero and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the sticky error |
| in_valid | input | 1 | A data phase is present |
| in_sop | input | 1 | This phase starts a new access |
| in_len | input | LEN_W | Access length in beats, sampled with in_sop |
| in_be | input | 4 | Byte enables of the phase |
| beat_ok | output | 1 | Current phase is valid and legal |
| err_flag | output | 1 | Sticky: an illegal phase was seen |
| err_beat | output | LEN_W | Index of the first illegal phase |

## Verification
A wrong remaining-beat count surfaces at `beat_ok` within the next beat or two of the same burst. It usually shows on a closing half-word or an opening upper half, which are judged differently in adjacent positions. The stimulus therefore leans on patterns that are legal in one position and illegal in the neighbour. A wrong beat-index count shows only when an error is recorded, one clock after the offending beat, as a wrong `err_beat` value. A sticky flag that fails to hold, or a clear that loses to a same-cycle error, shows at `err_flag` on the very next clock.

// File: rtl/be_burst_check.sv
module be_burst_check #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [LEN_W-1:0] in_len,
  input  logic [3:0]       in_be,
  output logic             beat_ok,
  output logic             err_flag,
  output logic [LEN_W-1:0] err_beat
);

  logic [LEN_W-1:0] rem_q, idx_q;
  logic [LEN_W-1:0] cur_idx;
  logic is_single, is_first, is_mid, is_last;
  logic ok_single, ok_first, ok_mid, ok_last, legal;

  assign is_single = in_sop && (in_len == LEN_W'(1));
  assign is_first  = in_sop && (in_len > LEN_W'(1));
  assign is_mid    = !in_sop && (rem_q > LEN_W'(1));
  assign is_last   = !in_sop && (rem_q == LEN_W'(1));

  assign ok_single = (in_be == 4'b1111) || (in_be == 4'b0011) || (in_be == 4'b1100) ||
                     (in_be == 4'b0001) || (in_be == 4'b0010) || (in_be == 4'b0100) ||
                     (in_be == 4'b1000);
  assign ok_first  = (in_be == 4'b1111) || (in_be == 4'b1100) || (in_be == 4'b1000);
  assign ok_mid    = (in_be == 4'b1111);
  assign ok_last   = (in_be == 4'b1111) || (in_be == 4'b0011) || (in_be == 4'b0001);

  assign legal = (is_single && ok_single) || (is_first && ok_first) ||
                 (is_mid && ok_mid) || (is_last && ok_last);

  assign beat_ok = in_valid && legal;
  assign cur_idx = in_sop ? '0 : idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      idx_q <= '0;
    end else if (in_valid) begin
      if (in_sop) begin
        rem_q <= (in_len == '0) ? '0 : in_len - LEN_W'(1);
        idx_q <= LEN_W'(1);
      end else begin
        rem_q <= (rem_q == '0) ? '0 : rem_q - LEN_W'(1);
        idx_q <= idx_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_beat <= '0;
    end else if (clr) begin
      err_flag <= 1'b0;
      err_beat <= '0;
    end else if (in_valid && !legal && !err_flag) begin
      err_flag <= 1'b1;
      err_beat <= cur_idx;
    end
  end

  p_zero_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_be == 4'b0000) |-> !beat_ok);

  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !beat_ok);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> (err_flag && $stable(err_beat)));

  p_catch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !beat_ok && !clr) |=> err_flag);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!err_flag && err_beat == '0));

  p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop && in_len == '0) |-> !beat_ok);

endmodule

// File: tb/test_be_burst_check.sv
module test_be_burst_check;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, in_valid = 1'b0, in_sop = 1'b0;
  logic [LEN_W-1:0] in_len = '0;
  logic [3:0] in_be = '0;
  logic beat_ok, err_flag;
  logic [LEN_W-1:0] err_beat;

  be_burst_check #(.LEN_W(LEN_W)) i_be_burst_check (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_sop(in_sop),
    .in_len(in_len), .in_be(in_be), .beat_ok(beat_ok), .err_flag(err_flag),
    .err_beat(err_beat)
  );

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  int m_rem = 0, m_idx = 0, m_err = 0, m_eidx = 0;
  bit done = 0;

  function automatic bit legal_be(int pos, logic [3:0] be);
    case (pos)
      0: return be inside {4'b1111, 4'b0011, 4'b1100, 4'b0001, 4'b0010, 4'b0100, 4'b1000};
      1: return be inside {4'b1111, 4'b1100, 4'b1000};
      2: return be == 4'b1111;
      3: return be inside {4'b1111, 4'b0011, 4'b0001};
      default: return 1'b0;
    endcase
  endfunction

  // 0 single, 1 first, 2 middle, 3 last, 4 no burst / zero length
  function automatic int position(bit sop, int len, int rem);
    if (sop) return (len == 0) ? 4 : (len == 1) ? 0 : 1;
    if (rem == 1) return 3;
    if (rem > 1) return 2;
    return 4;
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    vectors++;
    if (!cond) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit v, bit sop, int len, logic [3:0] be, bit c, string req);
    int pos, cur;
    bit exp_ok;
    @(negedge clk);
    in_valid = v; in_sop = sop; in_len = LEN_W'(len); in_be = be; clr = c;
    #1;
    pos = position(sop, len, m_rem);
    exp_ok = v && legal_be(pos, be);
    check(beat_ok == exp_ok, req, beat_ok, exp_ok);
    cur = sop ? 0 : m_idx;
    if (c) begin m_err = 0; m_eidx = 0; end
    else if (v && !exp_ok && m_err == 0) begin m_err = 1; m_eidx = cur; end
    if (v) begin
      if (sop) begin m_rem = (len == 0) ? 0 : len - 1; m_idx = 1; end
      else begin m_rem = (m_rem == 0) ? 0 : m_rem - 1; m_idx = (m_idx + 1) % (1 << LEN_W); end
    end
    @(posedge clk); #1;
    check(err_flag == m_err[0], "R9/R10 err_flag", err_flag, m_err);
    check(err_beat == LEN_W'(m_eidx), "R9/R10 err_beat", err_beat, m_eidx);
  endtask

  task automatic burst(int len, logic [3:0] fb, logic [3:0] mb, logic [3:0] lb, string req);
    for (int i = 0; i < len; i++)
      step(1, i == 0, len, (i == 0) ? fb : (i == len - 1) ? lb : mb, 0, req);
  endtask

  initial begin
    #200000000;
    miscompares++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [3:0] pats [7] = '{4'b1111, 4'b0011, 4'b1100, 4'b0001, 4'b0010, 4'b0100, 4'b1000};
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check(err_flag == 0, "R11 reset err_flag", err_flag, 0);
    check(err_beat == 0, "R11 reset err_beat", err_beat, 0);
    rst_n = 1'b1;
    step(1, 0, 0, 4'b1111, 0, "R11 no burst open after reset");
    step(0, 0, 0, 4'b0000, 1, "R10 clear");
    for (int b = 0; b < 16; b++) begin
      step(1, 1, 1, 4'(b), 0, "R1 single set / R5");
      step(0, 0, 0, 0, 1, "R10 clear");
    end
    for (int b = 0; b < 16; b++) begin
      step(1, 1, 3, 4'(b), 0, "R2 first beat");
      step(1, 0, 0, 4'b1111, 0, "R3 middle");
      step(1, 0, 0, 4'(b), 0, "R4 last beat");
      step(0, 0, 0, 0, 1, "R10 clear");
    end
    burst(4, 4'b1100, 4'b1111, 4'b0111, "R4 hole-free only");
    step(0, 0, 0, 0, 1, "R10");
    burst(5, 4'b1111, 4'b0000, 4'b0001, "R3 R5 middle zero");
    step(1, 1, 4, 4'b1111, 0, "R6 restart");
    step(1, 1, 2, 4'b1000, 1, "R10 clear wins R6 restart");
    step(1, 0, 0, 4'b0011, 0, "R6 last after restart");
    step(1, 0, 0, 4'b1111, 0, "R7 orphan beat");
    step(1, 1, 0, 4'b1111, 1, "R7 zero length with clear");
    step(1, 0, 0, 4'b1111, 0, "R7 none open after zero length");
    step(1, 1, 2, 4'b1100, 0, "R9 later errors ignored");
    step(0, 1, 5, 4'b0000, 0, "R8 idle");
    step(1, 0, 0, 4'b0001, 0, "R4");
    step(0, 0, 0, 0, 1, "R10");
    for (int n = 0; n < 600; n++) begin
      int len = $urandom_range(0, 6);
      int kind = $urandom_range(0, 9);
      if (kind == 0) step($urandom_range(0, 1), 0, 0, 4'($urandom), 0, "R7 R8 random orphan");
      else if (kind == 1) step(0, 0, 0, 0, 1, "R10 random clear");
      else for (int i = 0; i < (len == 0 ? 1 : len); i++) begin
        logic [3:0] be;
        if ($urandom_range(0, 7) == 0) be = 4'($urandom);
        else if (i == 0 && len > 1) be = pats[$urandom_range(0, 6)];
        else if (i == len - 1 && len > 1) be = pats[$urandom_range(0, 6)];
        else if (len <= 1) be = pats[$urandom_range(0, 6)];
        else be = 4'b1111;
        if ($urandom_range(0, 5) == 0) step(0, 0, 0, be, 0, "R8 gap");
        step(1, i == 0, len, be, ($urandom_range(0, 19) == 0), "R1-R6 random");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule